// File: doc/BRIEF.md
# Hit Timestamp and Epoch Event Merger

This block is the coarse-time core of a triggerless multi-channel time-to-digital front end. A free-running timestamp counter advances on every clock. Each hit that arrives on one of the hit channels becomes an event word that carries the counter value of the cycle in which the hit was seen. No trigger is needed to start a capture. When the counter rolls over, the block inserts an epoch marker word. The marker carries a running epoch number, so that software downstream can extend the short timestamps into absolute time.

An external sync input lets many chips share one time base. The block passes the sync line through a two-stage synchronizer and detects its rising edge. On the next clock edge it writes a sync marker word that holds the counter value just before the reload. It then reloads both the timestamp counter and the epoch number to zero. All events raised in one cycle enter a small FIFO in a fixed order. A downstream serializer drains the FIFO over a valid/ready handshake. Hits that find the FIFO too full are discarded and a sticky loss flag is raised. A few FIFO slots are kept free for markers, so that markers still get in while hits are being discarded.

Each event word is laid out from the most significant bit down as follows: a 2-bit kind, then a channel index, then the timestamp. With the default parameters this is a 24-bit word.

Top module: `tdc_stamp_merge`

## Requirements
- R1: A hit on channel c in a given cycle produces a word with kind 2'b00, channel field c and timestamp field equal to the counter value in that same cycle.
- R2: The counter counts up by one every cycle and rolls over from all-ones to zero. On the roll-over edge the block writes a word with kind 2'b01, channel field 0 and timestamp field equal to the epoch number after it has been incremented.
- R3: A rising edge on sync_in is seen after two synchronizer stages plus one edge-detect register. It yields exactly one word with kind 2'b10, channel field 0 and timestamp field equal to the counter value before the reload. On that edge the counter and the epoch number reload to zero. A sync level that stays high adds no further sync words.
- R4: If the sync reload falls in the same cycle as a counter roll-over, only the sync word is written and no epoch word appears.
- R5: Events raised in the same cycle enter the stream in this order: the sync or epoch marker first, then channels 0, 1, 2 and 3.
- R6: ev_valid is high exactly when the FIFO holds a word. A word leaves the FIFO on a cycle where ev_valid and ev_ready are both high. While ev_valid is high and ev_ready is low, ev_data does not change.
- R7: A hit is accepted only while the number of free FIFO slots, less the slots taken earlier in the same cycle, is greater than RESERVE. Otherwise the hit is discarded and hit_lost is set. hit_lost stays set until reset.
- R8: A sync or epoch word is accepted whenever at least one FIFO slot is free, even when hits are being discarded.
- R9: While rst_n is low at a clock edge, ev_valid and hit_lost are low afterwards and the counter restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sync_in | input | 1 | Asynchronous time-base realignment request |
| hit_in | input | NUM_CH | One pulse per hit, per channel, synchronous to clk |
| ev_valid | output | 1 | Event word available |
| ev_ready | input | 1 | Downstream takes the word this cycle |
| ev_data | output | 2+log2(NUM_CH)+TS_W | Event word: kind, channel, timestamp |
| hit_lost | output | 1 | Sticky flag: at least one hit was discarded |

## Verification
The bench first runs free with a ready sink, so that epoch words appear at each roll-over. It then sends single hits and multi-channel hit patterns; these separate wrong channel fields and wrong stamp cycles. A long sync level and a sync timed onto the roll-over cycle together with all four hits show whether sync produces one word, whether it suppresses the epoch word, and whether the order within a cycle is right. A stalled sink fed with hit bursts and then sync pulses separates how hits are discarded from how marker slots are reserved. A long run with random ready and random hits, followed by a reset in the middle of the run, tests the handshake and clearing the loss flag.

// File: rtl/evstamp_pkg.sv
// Shared encodings for the timestamp/event merger.
package evstamp_pkg;
    localparam int KIND_W = 2;

    typedef enum logic [KIND_W-1:0] {
        EV_HIT   = 2'b00,
        EV_EPOCH = 2'b01,
        EV_SYNC  = 2'b10
    } ev_kind_t;
endpackage

// File: rtl/sync_edge_det.sv
// Brings an asynchronous level into the clock domain through two flops
// and emits a one-cycle pulse on its rising edge.
// Assumes: the input stays high for at least two clock periods.
module sync_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic pulse
);
    logic meta_q, stable_q, prev_q;

    // Synchronizer chain plus the previous-value register for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q   <= 1'b0;
            stable_q <= 1'b0;
            prev_q   <= 1'b0;
        end else begin
            meta_q   <= async_in;
            stable_q <= meta_q;
            prev_q   <= stable_q;
        end
    end

    assign pulse = stable_q & ~prev_q;

    // R3
    one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);
endmodule

// File: rtl/ts_epoch_counter.sv
// Free-running coarse timestamp with an epoch number that counts roll-overs.
// A sync pulse reloads both to zero and takes precedence over a roll-over.
// Assumes: sync_pulse is at most one cycle wide.
module ts_epoch_counter #(
    parameter int TS_W = 20
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sync_pulse,
    output logic [TS_W-1:0] ts,
    output logic [TS_W-1:0] epoch_next,
    output logic            wrap
);
    localparam logic [TS_W-1:0] TS_MAX = '1;

    logic [TS_W-1:0] epoch_q;

    assign wrap       = (ts == TS_MAX) && !sync_pulse;
    assign epoch_next = epoch_q + 1'b1;

    // Advance the timestamp; reload on sync, bump the epoch on roll-over.
    always_ff @(posedge clk) begin
        if (!rst_n || sync_pulse) begin
            ts      <= '0;
            epoch_q <= '0;
        end else begin
            ts <= ts + 1'b1;
            if (wrap) begin
                epoch_q <= epoch_next;
            end
        end
    end

    // R2
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_pulse && ts != TS_MAX) |=> ts == TS_W'($past(ts) + 1'b1));
    // R2
    rollover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ts == TS_MAX) |=> ts == '0);
    // R3
    sync_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_pulse |=> (ts == '0 && epoch_q == '0));
    // R4
    no_wrap_on_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_pulse |-> !wrap);
endmodule

// File: rtl/ev_merge_fifo.sv
// Accepts up to NSRC event words per cycle in index order (lowest first)
// into a circular buffer, and serves them over valid/ready.
// Sources below NMARK are markers that may use every free slot; the
// others are hits, which leave RESERVE slots untouched and are dropped
// (setting a sticky flag) when space is short.
// Assumes: DEPTH is a power of two and DEPTH >= NSRC.
module ev_merge_fifo #(
    parameter int EV_W    = 24,
    parameter int NSRC    = 6,
    parameter int NMARK   = 2,
    parameter int DEPTH   = 8,
    parameter int RESERVE = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NSRC-1:0]            src_vld,
    input  logic [NSRC-1:0][EV_W-1:0]  src_word,
    output logic                       out_valid,
    input  logic                       out_ready,
    output logic [EV_W-1:0]            out_data,
    output logic                       hit_lost
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [EV_W-1:0] mem [DEPTH];
    logic [AW-1:0]   wr_ptr, rd_ptr;
    logic [CW-1:0]   count;
    logic [NSRC-1:0] acc;
    logic [AW-1:0]   ofs [NSRC];
    int              n_acc;
    logic            drop_now;
    logic            pop;

    assign out_valid = (count != '0);
    assign out_data  = mem[rd_ptr];
    assign pop       = out_valid && out_ready;

    // Walk the sources in priority order and assign each accepted one a slot.
    always_comb begin
        int free_slots;
        int taken;
        free_slots = DEPTH - int'(count);
        taken      = 0;
        drop_now   = 1'b0;
        for (int i = 0; i < NSRC; i++) begin
            acc[i] = 1'b0;
            ofs[i] = AW'(taken);
            if (src_vld[i]) begin
                if ((i < NMARK) ? (free_slots > taken)
                                : (free_slots > taken + RESERVE)) begin
                    acc[i] = 1'b1;
                    taken  = taken + 1;
                end else if (i >= NMARK) begin
                    drop_now = 1'b1;
                end
            end
        end
        n_acc = taken;
    end

    // Storage writes for the accepted sources.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NSRC; i++) begin
            if (acc[i]) begin
                mem[wr_ptr + ofs[i]] <= src_word[i];
            end
        end
    end

    // Pointers, fill level and the sticky loss flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            count    <= '0;
            hit_lost <= 1'b0;
        end else begin
            wr_ptr <= wr_ptr + AW'(n_acc);
            rd_ptr <= rd_ptr + AW'(pop);
            count  <= count + CW'(n_acc) - CW'(pop);
            if (drop_now) begin
                hit_lost <= 1'b1;
            end
        end
    end

    // R6
    fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    // R6
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
    // R7
    lost_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_lost |=> hit_lost);
    // R8
    marker_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|src_vld[NMARK-1:0]) && count < CW'(DEPTH)) |=> out_valid);
endmodule

// File: rtl/tdc_stamp_merge.sv
// Top level: coarse timestamp counter, sync capture, epoch markers and
// per-channel hit stamping merged onto one event stream.
// Word layout (MSB first): kind, channel, timestamp.
// Assumes: hit_in pulses are synchronous to clk; NUM_CH >= 2.
module tdc_stamp_merge #(
    parameter int NUM_CH  = 4,
    parameter int TS_W    = 20,
    parameter int DEPTH   = 8,
    parameter int RESERVE = 2,
    localparam int CH_W   = $clog2(NUM_CH),
    localparam int EV_W   = evstamp_pkg::KIND_W + CH_W + TS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_in,
    input  logic [NUM_CH-1:0] hit_in,
    output logic              ev_valid,
    input  logic              ev_ready,
    output logic [EV_W-1:0]   ev_data,
    output logic              hit_lost
);
    import evstamp_pkg::*;

    localparam int NMARK = 2;
    localparam int NSRC  = NMARK + NUM_CH;

    logic                      sync_pulse;
    logic [TS_W-1:0]           ts, epoch_next;
    logic                      wrap;
    logic [NSRC-1:0]           src_vld;
    logic [NSRC-1:0][EV_W-1:0] src_word;

    sync_edge_det u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (sync_in),
        .pulse    (sync_pulse)
    );

    ts_epoch_counter #(.TS_W(TS_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_pulse (sync_pulse),
        .ts         (ts),
        .epoch_next (epoch_next),
        .wrap       (wrap)
    );

    // Marker sources: sync ahead of epoch (they never coincide).
    assign src_vld[0]  = sync_pulse;
    assign src_word[0] = {EV_SYNC, {CH_W{1'b0}}, ts};
    assign src_vld[1]  = wrap;
    assign src_word[1] = {EV_EPOCH, {CH_W{1'b0}}, epoch_next};

    // One hit source per channel, stamped with the current count.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_hit
        assign src_vld[NMARK + c]  = hit_in[c];
        assign src_word[NMARK + c] = {EV_HIT, CH_W'(c), ts};
    end

    ev_merge_fifo #(
        .EV_W    (EV_W),
        .NSRC    (NSRC),
        .NMARK   (NMARK),
        .DEPTH   (DEPTH),
        .RESERVE (RESERVE)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_vld   (src_vld),
        .src_word  (src_word),
        .out_valid (ev_valid),
        .out_ready (ev_ready),
        .out_data  (ev_data),
        .hit_lost  (hit_lost)
    );

    // R1
    hit_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit_in && !ev_valid) |=> ev_valid);
endmodule

// File: tb/tb_tdc_stamp_merge.sv
module tb_tdc_stamp_merge;
    localparam int NUM_CH  = 4;
    localparam int TS_W    = 6;
    localparam int DEPTH   = 8;
    localparam int RESERVE = 2;
    localparam int CH_W    = 2;
    localparam int EV_W    = 2 + CH_W + TS_W;
    localparam int MAXV    = (1 << TS_W) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sync_in = 1'b0;
    logic [NUM_CH-1:0] hit_in = '0;
    logic              ev_ready = 1'b0;
    logic              ev_valid;
    logic [EV_W-1:0]   ev_data;
    logic              hit_lost;

    always #2 clk = ~clk;

    tdc_stamp_merge #(
        .NUM_CH(NUM_CH), .TS_W(TS_W), .DEPTH(DEPTH), .RESERVE(RESERVE)
    ) dut (
        .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .hit_in(hit_in),
        .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_data(ev_data),
        .hit_lost(hit_lost)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Behavioural reference state.
    int              m_cnt = 0;
    int              m_ep  = 0;
    bit              m_s1, m_s2, m_s3, m_lost;
    logic [EV_W-1:0] m_q[$];

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model: advanced on every rising edge from its own state.
    always @(posedge clk) begin
        int  free_slots, n, old;
        bit  pop, pulse;
        if (!rst_n) begin
            m_cnt = 0; m_ep = 0; m_lost = 0;
            m_s1 = 0; m_s2 = 0; m_s3 = 0;
            m_q.delete();
        end else begin
            free_slots = DEPTH - m_q.size();
            pop   = (m_q.size() > 0) && ev_ready;
            pulse = m_s2 && !m_s3;
            old   = m_cnt;
            n     = 0;
            if (pulse) begin
                if (free_slots > n) begin
                    m_q.push_back({2'b10, CH_W'(0), TS_W'(old)}); n++;
                end
                m_cnt = 0; m_ep = 0;
            end else if (old == MAXV) begin
                m_ep = (m_ep + 1) & MAXV;
                if (free_slots > n) begin
                    m_q.push_back({2'b01, CH_W'(0), TS_W'(m_ep)}); n++;
                end
                m_cnt = 0;
            end else begin
                m_cnt = old + 1;
            end
            for (int ch = 0; ch < NUM_CH; ch++) begin
                if (hit_in[ch]) begin
                    if (free_slots - n > RESERVE) begin
                        m_q.push_back({2'b00, CH_W'(ch), TS_W'(old)}); n++;
                    end else begin
                        m_lost = 1;
                    end
                end
            end
            if (pop) void'(m_q.pop_front());
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = sync_in;
        end
    end

    // Compare against the model away from the active edge.
    always @(negedge clk) begin
        logic [EV_W-1:0] exp_w;
        if (!done) begin
            if (!rst_n) begin
                // R9: reset state
                chk(ev_valid === 1'b0, "R9 ev_valid in reset", 32'(ev_valid), 0);
                chk(hit_lost === 1'b0, "R9 hit_lost in reset", 32'(hit_lost), 0);
            end else begin
                // R6: valid mirrors occupancy
                chk(ev_valid === (m_q.size() > 0), "R6 ev_valid",
                    32'(ev_valid), 32'(m_q.size() > 0));
                if (m_q.size() > 0) begin
                    exp_w = m_q[0];
                    case (exp_w[EV_W-1 -: 2])
                        2'b10:   chk(ev_data === exp_w, "R3/R4/R8 sync word", 32'(ev_data), 32'(exp_w));
                        2'b01:   chk(ev_data === exp_w, "R2/R4/R8 epoch word", 32'(ev_data), 32'(exp_w));
                        default: chk(ev_data === exp_w, "R1/R5 hit word", 32'(ev_data), 32'(exp_w));
                    endcase
                end
                // R7: sticky loss flag
                chk(hit_lost === m_lost, "R7 hit_lost", 32'(hit_lost), 32'(m_lost));
            end
        end
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R6 watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        // R9: reset
        repeat (3) step();
        rst_n = 1'b1;

        // R2: free running with epoch words at each roll-over
        ev_ready = 1'b1;
        repeat (150) step();

        // R1: single hits on every channel, then multi-channel patterns
        for (int ch = 0; ch < NUM_CH; ch++) begin
            hit_in = NUM_CH'(1 << ch); step();
            hit_in = '0; repeat (3) step();
        end
        hit_in = 4'b1111; step();
        hit_in = 4'b1010; step();
        hit_in = 4'b0101; step();
        hit_in = '0; repeat (10) step();

        // R3: long sync level yields one sync word
        sync_in = 1'b1; repeat (6) step();
        sync_in = 1'b0; repeat (12) step();

        // R4, R5: sync reload lands on the roll-over cycle together with all hits
        while (m_cnt != MAXV - 2) step();
        sync_in = 1'b1; step(); step();
        hit_in = 4'b1111; step();
        hit_in = '0; sync_in = 1'b0; repeat (12) step();

        // R2, R5: epoch together with all hits
        while (m_cnt != MAXV) step();
        hit_in = 4'b1111; step();
        hit_in = '0; repeat (12) step();

        // R7, R8: stalled sink, hit bursts, then syncs into reserved slots
        ev_ready = 1'b0;
        hit_in = 4'b1111; repeat (4) step();
        hit_in = '0;
        sync_in = 1'b1; repeat (4) step();
        sync_in = 1'b0; repeat (4) step();
        sync_in = 1'b1; repeat (4) step();
        sync_in = 1'b0; repeat (4) step();
        ev_ready = 1'b1; repeat (12) step();

        // R6: random backpressure with random hits and occasional syncs
        for (int i = 0; i < 3000; i++) begin
            ev_ready = 1'($urandom_range(0, 1));
            for (int ch = 0; ch < NUM_CH; ch++)
                hit_in[ch] = ($urandom_range(0, 3) == 0);
            if (i % 300 == 100) sync_in = 1'b1;
            if (i % 300 == 106) sync_in = 1'b0;
            step();
        end
        hit_in = '0; sync_in = 1'b0;

        // R7, R9: reset mid-run clears the loss flag
        rst_n = 1'b0; repeat (2) step();
        rst_n = 1'b1;
        ev_ready = 1'b1;
        hit_in = 4'b0011; step();
        hit_in = '0; repeat (80) step();

        finish_run();
    end
endmodule